// File: doc/BRIEF.md
# Branch Direction Predictor Table

This block predicts whether a conditional branch is taken. It holds a table of two-bit saturating counters, one per entry, and selects an entry from the low word-address bits of a branch's program counter. A fetch-side lookup port takes a PC and returns, in the same cycle, the selected counter and a taken/not-taken prediction drawn from it. An execute-side update port takes the PC of a resolved branch and its actual outcome. It moves that entry's counter one step through the state machine at the next clock edge.

The state machine is asymmetric. A counter in the strongly-taken state that sees one not-taken outcome falls straight to weakly-not-taken. It does not step down to weakly-taken. All other transitions are the usual saturating steps. Distinct branches whose word addresses differ in the index bits train separate counters. Branches that share index bits alias onto one counter.

Top module: `bp_dir_predictor`

## Requirements
- R1: While reset is asserted, and after it is released, every counter reads 01 (weakly not taken) and the prediction is not taken.
- R2: The prediction `lkp_taken` equals bit 1 of the selected counter (1 = taken), and `lkp_ctr` shows that counter with the encoding 00 strongly not taken, 01 weakly not taken, 10 weakly taken, 11 strongly taken.
- R3: With `IDX_W` index bits, the entry is selected by PC[IDX_W+1:2]. PC bits 1:0 and bits above IDX_W+1 have no effect on which entry is read or written.
- R4: An update to a counter at 00 leaves it at 00 when not taken and moves it to 01 when taken.
- R5: An update to a counter at 01 moves it to 00 when not taken and to 10 when taken.
- R6: An update to a counter at 10 moves it to 01 when not taken and to 11 when taken.
- R7: An update to a counter at 11 leaves it at 11 when taken and moves it directly to 01 when not taken.
- R8: With `upd_valid` low, no counter changes. A valid update changes only the entry its PC selects.
- R9: A lookup in the same cycle as an update to the same entry returns the counter value from before the update. The new value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lkp_pc | input | PC_W | PC of the branch being predicted |
| lkp_taken | output | 1 | Prediction for `lkp_pc`, 1 = taken |
| lkp_ctr | output | 2 | Counter selected by `lkp_pc` |
| upd_valid | input | 1 | Update request qualifier |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions assume that `upd_valid`, `upd_pc` and `upd_taken` are known and are held stable around each rising clock edge. They also assume that nothing is sampled until the internally synchronised reset has been released. The bench drives every input on the falling edge. It keeps every input at a defined value from time zero and waits out the reset synchroniser before it sends the first update. Random PCs cover all 32 bits, including the byte-offset and upper bits. This keeps aliased and colliding accesses within the assumptions while still exercising them.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  localparam logic [1:0] CTR_INIT = CTR_WNT;

endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bp_pc_index.sv
module bp_pc_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);

  localparam int LSB = 2;
  localparam int MSB = IDX_W + LSB - 1;

  assign idx = pc[MSB:LSB];

endmodule

// File: rtl/bp_ctr_next.sv
module bp_ctr_next
  import bp_pkg::*;
(
  input  logic [1:0] cur,
  input  logic       taken,
  output logic [1:0] nxt
);

  always_comb begin
    nxt = cur;
    unique case (ctr_e'(cur))
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      CTR_ST:  nxt = taken ? CTR_ST  : CTR_WNT;
      default: nxt = CTR_INIT;
    endcase
  end

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic [IDX_W-1:0] mod_idx,
  output logic [1:0]       mod_ctr,
  input  logic             wr_en,
  input  logic [1:0]       wr_ctr
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0][1:0] ctr_q;
  logic [ENTRIES-1:0][1:0] ctr_d;
  logic [ENTRIES-1:0]      ent_en;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign ent_en[g] = wr_en && (mod_idx == IDX_W'(g));

    always_comb begin
      ctr_d[g] = ctr_q[g];
      if (ent_en[g]) begin
        ctr_d[g] = wr_ctr;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctr_q[g] <= CTR_INIT;
      end else if (ent_en[g]) begin
        ctr_q[g] <= ctr_d[g];
      end
    end
  end

  assign rd_ctr  = ctr_q[rd_idx];
  assign mod_ctr = ctr_q[mod_idx];

  // R8: an idle cycle leaves every counter untouched
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctr_q));

  // R9: a write is visible in the addressed entry from the next cycle
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctr_q[$past(mod_idx)] == $past(wr_ctr));

endmodule

// File: rtl/bp_dir_predictor.sv
module bp_dir_predictor
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lkp_pc,
  output logic            lkp_taken,
  output logic [1:0]      lkp_ctr,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  logic             rst_sync_n;
  logic [IDX_W-1:0] lkp_idx;
  logic [IDX_W-1:0] upd_idx;
  logic [1:0]       upd_cur;
  logic [1:0]       upd_nxt;

  bp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bp_pc_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lkp_index (
    .pc  (lkp_pc),
    .idx (lkp_idx)
  );

  bp_pc_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_upd_index (
    .pc  (upd_pc),
    .idx (upd_idx)
  );

  bp_ctr_table #(.IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_idx  (lkp_idx),
    .rd_ctr  (lkp_ctr),
    .mod_idx (upd_idx),
    .mod_ctr (upd_cur),
    .wr_en   (upd_valid),
    .wr_ctr  (upd_nxt)
  );

  bp_ctr_next u_next (
    .cur   (upd_cur),
    .taken (upd_taken),
    .nxt   (upd_nxt)
  );

  assign lkp_taken = lkp_ctr[1];

  // R4: a strongly-not-taken counter stays put on a not-taken outcome
  a_r4_floor_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && upd_cur == CTR_SNT && !upd_taken) |-> upd_nxt == CTR_SNT);

  // R6: a weakly-taken counter reaches the strong state on a taken outcome
  a_r6_reach_strong: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && upd_cur == CTR_WT && upd_taken) |-> upd_nxt == CTR_ST);

  // R7: one miss in the strong-taken state lands in weakly-not-taken
  a_r7_strong_miss: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && upd_cur == CTR_ST && !upd_taken) |=>
      $past(upd_nxt) == CTR_WNT);

  // R5: from weakly-not-taken the counter always leaves that state
  a_r5_weak_moves: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && upd_cur == CTR_WNT) |-> upd_nxt != CTR_WNT);

endmodule

// File: tb/bp_dir_predictor_bench.sv
module bp_dir_predictor_bench;

  localparam int PC_W  = 32;
  localparam int IDX_W = 6;
  localparam int ENT   = 1 << IDX_W;

  logic            clk;
  logic            rst_n;
  logic [PC_W-1:0] lkp_pc;
  logic            lkp_taken;
  logic [1:0]      lkp_ctr;
  logic            upd_valid;
  logic [PC_W-1:0] upd_pc;
  logic            upd_taken;

  int checks;
  int errors;
  bit done;
  logic [1:0] model [ENT];

  bp_dir_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_bp_dir_predictor (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_pc    (lkp_pc),
    .lkp_taken (lkp_taken),
    .lkp_ctr   (lkp_ctr),
    .upd_valid (upd_valid),
    .upd_pc    (upd_pc),
    .upd_taken (upd_taken)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic [1:0] step_ctr(logic [1:0] c, logic t);
    case (c)
      2'b00:   return t ? 2'b01 : 2'b00;
      2'b01:   return t ? 2'b10 : 2'b00;
      2'b10:   return t ? 2'b11 : 2'b01;
      default: return t ? 2'b11 : 2'b01;
    endcase
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // drive at the falling edge, check lookup, then let the edge write
  task automatic cyc(logic [PC_W-1:0] lpc, logic uv, logic [PC_W-1:0] upc,
                     logic ut, string req);
    @(negedge clk);
    lkp_pc    = lpc;
    upd_valid = uv;
    upd_pc    = upc;
    upd_taken = ut;
    #1;
    chk(req, lkp_ctr, model[idx_of(lpc)]);
    chk({req, "/R2"}, {1'b0, lkp_taken}, {1'b0, model[idx_of(lpc)][1]});
    @(posedge clk);
    if (uv) model[idx_of(upc)] = step_ctr(model[idx_of(upc)], ut);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-reqs actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] pa;
    logic [PC_W-1:0] pb;
    checks = 0;
    errors = 0;
    done = 1'b0;
    for (int i = 0; i < ENT; i++) model[i] = 2'b01;
    rst_n = 1'b0;
    lkp_pc = '0;
    upd_valid = 1'b0;
    upd_pc = '0;
    upd_taken = 1'b0;
    #20;
    // R1: counters at weakly-not-taken during reset
    for (int i = 0; i < 4; i++) begin
      lkp_pc = PC_W'(i * 44);
      #1;
      chk("R1", lkp_ctr, 2'b01);
      chk("R1", {1'b0, lkp_taken}, 2'b00);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    pa = 32'h0000_0010;
    pb = 32'h0000_0014;
    cyc(pa, 1'b0, pa, 1'b0, "R1");
    // walk every state and both outcomes
    cyc(pa, 1'b1, pa, 1'b0, "R5");
    cyc(pa, 1'b1, pa, 1'b0, "R5");
    cyc(pa, 1'b1, pa, 1'b1, "R4");
    cyc(pa, 1'b1, pa, 1'b1, "R4");
    cyc(pa, 1'b1, pa, 1'b1, "R5");
    cyc(pa, 1'b1, pa, 1'b1, "R6");
    cyc(pa, 1'b1, pa, 1'b0, "R7");
    cyc(pa, 1'b0, pa, 1'b0, "R7");
    chk("R7", lkp_ctr, 2'b01);
    cyc(pa, 1'b1, pa, 1'b1, "R5");
    cyc(pa, 1'b1, pa, 1'b0, "R6");
    cyc(pa, 1'b0, pa, 1'b0, "R6");
    chk("R6", lkp_ctr, 2'b01);
    // R9: same-cycle lookup sees old value
    cyc(pa, 1'b1, pa, 1'b1, "R9");
    cyc(pa, 1'b0, pa, 1'b0, "R9");
    chk("R9", lkp_ctr, 2'b10);
    // R8: invalid update ignored, neighbour untouched
    cyc(pb, 1'b0, pb, 1'b1, "R8");
    cyc(pb, 1'b0, pb, 1'b1, "R8");
    chk("R8", lkp_ctr, 2'b01);
    cyc(pb, 1'b1, pa, 1'b1, "R8");
    cyc(pb, 1'b0, pa, 1'b0, "R8");
    chk("R8", lkp_ctr, 2'b01);
    // R3: offset and upper bits do not affect selection
    cyc(32'h0000_001C, 1'b1, 32'hABCD_E01F, 1'b0, "R3");
    cyc(32'h5555_501C, 1'b0, '0, 1'b0, "R3");
    chk("R3", lkp_ctr, 2'b00);

    for (int n = 0; n < 4000; n++) begin
      logic [PC_W-1:0] rl;
      logic [PC_W-1:0] ru;
      rl = $urandom();
      ru = (n % 3 == 0) ? rl : $urandom();
      cyc(rl, 1'($urandom()), ru, ($urandom() % 4) != 0, "R4-R7-random");
    end

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
  end

endmodule